// File: doc/BRIEF.md
# ODT Power-Down Transition Window Tracker

This block sits on the controller side of a DDR3-class memory interface. It watches the registered CKE level as the controller enters precharge power-down. For every clock cycle it reports how the on-die termination in the memory behaves: synchronous, uncertain (transition), or asynchronous. It also reports, through a flag, any ODT level change that lands inside the uncertain stretch.

The uncertain stretch opens a number of cycles before the cycle in which CKE is first seen low. Because of that, the tracker outputs every result WL-1 cycles after the input cycle it describes. The ODT level is delayed by the same amount and is presented next to the mode code.

The stretch closes at the end of the minimum power-down entry delay (tcpded_i cycles). If a refresh is still running when CKE falls, it closes at the end of that refresh instead, whichever comes later. The tracker only reports a transition when the DLL-freeze option for precharge power-down is selected. When that option is off, every cycle is synchronous.

Top module: `odt_pdw_tracker`

## Requirements
- R1: The mode code is 2 bits: 00 synchronous, 01 transition, 10 asynchronous; 11 never appears. While rst_n is low, and after its release with CKE high, mode_o is 00 and odt_unc_o is 0.
- R2: If dll_frz_i is 0 in the cycle where CKE is first seen low (cke_q_i was 1 the cycle before), mode_o stays 00 and odt_unc_o stays 0 for that whole power-down episode.
- R3: Outputs are delayed by D = WL-1 cycles: the values shown in cycle t describe input cycle t-D. With c0 the first CKE-low cycle, input cycle c0-D is still synchronous and input cycle c0-D+1 is the first transition cycle.
- R4: Without a refresh in progress, the last transition input cycle is c0+tcpded_i-1 and it is included; a tcpded_i of 0 acts as 1.
- R5: A refresh strobe in input cycle r with trfc_i=F keeps the refresh in progress through input cycle r+F-1. If that cycle is at or after c0, the last transition cycle becomes the later of r+F-1 and c0+tcpded_i-1. A refresh that has finished before c0 has no effect.
- R6: After the last transition cycle, input cycles with CKE low are reported as 10. Input cycles with CKE high that lie outside the transition stretch are reported as 00, including after an early power-down exit.
- R7: odt_dly_o shows odt_i delayed by D cycles. odt_unc_o is 1 exactly when odt_i differs between input cycles n-1 and n and input cycle n is a transition cycle.
- R8: wl_i from 2 to 16 gives D = wl_i-1. Values below 2 act as 2, and values above 16 act as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_q_i | input | 1 | Registered CKE level driven to the memory |
| ref_i | input | 1 | One-cycle strobe for each refresh command issued |
| dll_frz_i | input | 1 | 1 when the DLL is frozen in precharge power-down |
| wl_i | input | 5 | Write latency in cycles |
| tcpded_i | input | 9 | Minimum power-down entry delay in cycles |
| trfc_i | input | 9 | Minimum refresh cycle time in cycles |
| odt_i | input | 1 | ODT level driven to the memory |
| mode_o | output | 2 | Delayed ODT mode code |
| odt_dly_o | output | 1 | ODT level aligned with mode_o |
| odt_unc_o | output | 1 | ODT change inside the transition stretch |

## Verification
The bench keeps the default build (maximum write latency 16, 9-bit cycle counts) and changes wl_i from scenario to scenario. It runs with the shortest delay (wl_i=2, where the stretch begins at c0 itself) and with the deepest tap (wl_i=16). Refresh timing is chosen so that the refresh end lands past the entry delay, short of it, or just before c0. ODT is toggled on the excluded start cycle, the first cycle, the last cycle and the first cycle after the stretch, so that each inclusive or exclusive boundary is observed.

// File: rtl/odt_pdw_pkg.sv
package odt_pdw_pkg;
  typedef enum logic [1:0] {
    PDW_SYNC  = 2'b00,
    PDW_TRANS = 2'b01,
    PDW_ASYNC = 2'b10
  } pdw_mode_e;
endpackage

// File: rtl/odt_pdw_delay.sv
// Fixed-depth shift line with a runtime-selected tap; stage j holds input t-1-j.
module odt_pdw_delay #(
  parameter int             DEPTH   = 16,
  parameter int             W       = 2,
  parameter logic [W-1:0]   RST_VAL = '0,
  localparam int            IDX_W   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     din,
  input  logic [IDX_W-1:0] tap,
  output logic [W-1:0]     dout_cur,
  output logic [W-1:0]     dout_prev
);
  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];
  logic [IDX_W-1:0] tap_nxt;

  assign stg_d[0] = din;

  for (genvar gi = 1; gi < DEPTH; gi++) begin : g_next
    assign stg_d[gi] = stg_q[gi-1];
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[gi] <= RST_VAL;
      else        stg_q[gi] <= stg_d[gi];
    end
  end

  assign tap_nxt   = tap + 1'b1;
  assign dout_cur  = stg_q[tap];
  assign dout_prev = stg_q[tap_nxt];
endmodule

// File: rtl/odt_pdw_rfc.sv
// Tracks how many cycles of the most recent refresh remain.
module odt_pdw_rfc #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_i,
  input  logic [CNT_W-1:0] trfc_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] rem_o
);
  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    cnt_en = ref_i | act_q;
    if (ref_i) begin
      act_d = (trfc_i > CNT_W'(1));
      cnt_d = (trfc_i > CNT_W'(1)) ? trfc_i - CNT_W'(2) : '0;
    end else if (act_q) begin
      act_d = (cnt_q != '0);
      cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    if (ref_i) begin
      busy_o = (trfc_i != '0);
      rem_o  = (trfc_i != '0) ? trfc_i - 1'b1 : '0;
    end else begin
      busy_o = act_q;
      rem_o  = cnt_q;
    end
  end

  // R5
  rfc_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q == '0 && !ref_i) |=> !act_q);
endmodule

// File: rtl/odt_pdw_window.sv
// Window length counter and mode classification in delayed (output) time.
module odt_pdw_window
  import odt_pdw_pkg::*;
#(
  parameter int DLY_W = 4,
  parameter int CNT_W = 9,
  localparam int WIN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_fall_i,
  input  logic             frz_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [CNT_W-1:0] tcpded_i,
  input  logic             rfc_busy_i,
  input  logic [CNT_W-1:0] rfc_rem_i,
  input  logic             cke_dly_i,
  input  logic             odt_cur_i,
  input  logic             odt_prev_i,
  output pdw_mode_e        mode_o,
  output logic             unc_o
);
  logic [WIN_W-1:0] win_q, win_d;
  logic             frz_q, frz_d;
  logic             load;
  logic             win_en;
  logic [CNT_W-1:0] base_end;
  logic [CNT_W-1:0] end_off;
  logic [WIN_W-1:0] win_len;

  assign load = cke_fall_i & frz_i;

  always_comb begin
    base_end = (tcpded_i == '0) ? '0 : tcpded_i - 1'b1;
    end_off  = (rfc_busy_i && rfc_rem_i > base_end) ? rfc_rem_i : base_end;
    win_len  = WIN_W'(dly_i) + WIN_W'(end_off);
  end

  always_comb begin
    win_d  = win_q;
    frz_d  = frz_q;
    win_en = load | (win_q != '0) | cke_fall_i;
    if (load)               win_d = win_len;
    else if (win_q != '0)   win_d = win_q - 1'b1;
    if (cke_fall_i)         frz_d = frz_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      frz_q <= 1'b0;
    end else if (win_en) begin
      win_q <= win_d;
      frz_q <= frz_d;
    end
  end

  always_comb begin
    if (win_q != '0)             mode_o = PDW_TRANS;
    else if (frz_q && !cke_dly_i) mode_o = PDW_ASYNC;
    else                          mode_o = PDW_SYNC;
    unc_o = (mode_o == PDW_TRANS) && (odt_cur_i != odt_prev_i);
  end

  // R1
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11);

  // R7
  flag_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unc_o |-> mode_o == PDW_TRANS);

  // R6
  async_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PDW_ASYNC && !load) |=> mode_o != PDW_TRANS);
endmodule

// File: rtl/odt_pdw_tracker.sv
module odt_pdw_tracker
  import odt_pdw_pkg::*;
#(
  parameter int MAX_WL = 16,
  parameter int CNT_W  = 9,
  localparam int WL_W  = $clog2(MAX_WL + 1),
  localparam int DLY_W = $clog2(MAX_WL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_q_i,
  input  logic             ref_i,
  input  logic             dll_frz_i,
  input  logic [WL_W-1:0]  wl_i,
  input  logic [CNT_W-1:0] tcpded_i,
  input  logic [CNT_W-1:0] trfc_i,
  input  logic             odt_i,
  output logic [1:0]       mode_o,
  output logic             odt_dly_o,
  output logic             odt_unc_o
);
  logic             cke_prev_q;
  logic             cke_fall;
  logic [WL_W-1:0]  wl_eff;
  logic [DLY_W-1:0] dly;
  logic [DLY_W-1:0] tap;
  logic [1:0]       line_cur, line_prev;
  logic             rfc_busy;
  logic [CNT_W-1:0] rfc_rem;
  pdw_mode_e        mode;
  logic             unc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_prev_q <= 1'b1;
    else        cke_prev_q <= cke_q_i;
  end

  assign cke_fall = cke_prev_q & ~cke_q_i;

  always_comb begin
    if (wl_i < WL_W'(2))           wl_eff = WL_W'(2);
    else if (wl_i > WL_W'(MAX_WL)) wl_eff = WL_W'(MAX_WL);
    else                           wl_eff = wl_i;
    dly = DLY_W'(wl_eff - 1'b1);
    tap = dly - 1'b1;
  end

  odt_pdw_delay #(
    .DEPTH   (MAX_WL),
    .W       (2),
    .RST_VAL (2'b01)
  ) i_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       ({odt_i, cke_q_i}),
    .tap       (tap),
    .dout_cur  (line_cur),
    .dout_prev (line_prev)
  );

  odt_pdw_rfc #(
    .CNT_W (CNT_W)
  ) i_rfc (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_i  (ref_i),
    .trfc_i (trfc_i),
    .busy_o (rfc_busy),
    .rem_o  (rfc_rem)
  );

  odt_pdw_window #(
    .DLY_W (DLY_W),
    .CNT_W (CNT_W)
  ) i_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke_fall_i (cke_fall),
    .frz_i      (dll_frz_i),
    .dly_i      (dly),
    .tcpded_i   (tcpded_i),
    .rfc_busy_i (rfc_busy),
    .rfc_rem_i  (rfc_rem),
    .cke_dly_i  (line_cur[0]),
    .odt_cur_i  (line_cur[1]),
    .odt_prev_i (line_prev[1]),
    .mode_o     (mode),
    .unc_o      (unc)
  );

  assign mode_o    = mode;
  assign odt_dly_o = line_cur[1];
  assign odt_unc_o = unc;

  // R3
  entry_trans_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_fall && dll_frz_i) |=> mode_o == 2'b01);
endmodule

// File: tb/test_odt_pdw_tracker.sv
module test_odt_pdw_tracker;
  typedef struct packed {
    int wl; int tc; int trfc; int refk; int frz; int pdl; int tog;
  } scen_t;

  // fields: wl, tcpded, trfc, refresh k cycles before c0 (-1 none), freeze, pd length, odt toggle (rel c0)
  localparam int NSC = 12;
  localparam scen_t TBL [NSC] = '{
    '{5,  1,  0, -1, 1, 30, -4},  // R3 excluded start cycle, no flag
    '{5,  1,  0, -1, 1, 30, -3},  // R3 first window cycle flagged
    '{8,  4,  0, -1, 1, 40,  3},  // R4 last included cycle
    '{8,  4,  0, -1, 1, 40,  4},  // R4 R6 first async cycle
    '{6,  5, 20,  2, 1, 60, 17},  // R5 refresh end later, included
    '{6,  5, 20,  2, 1, 60, 18},  // R5 one past refresh end
    '{6, 10,  8,  2, 1, 40,  9},  // R5 refresh ends first
    '{6,  3,  8,  8, 1, 30,  2},  // R5 refresh done before c0
    '{5,  4,  0, -1, 0, 30,  0},  // R2 freeze off
    '{16, 2,  0, -1, 1, 40, -14}, // R8 deepest tap
    '{5, 20,  0, -1, 1,  5, 10},  // R6 early exit
    '{2,  1,  0, -1, 1, 10,  0}   // R8 shortest delay
  };

  logic       clk;
  logic       rst_n;
  logic       cke_q_i, ref_i, dll_frz_i, odt_i;
  logic [4:0] wl_i;
  logic [8:0] tcpded_i, trfc_i;
  logic [1:0] mode_o;
  logic       odt_dly_o, odt_unc_o;

  int n_chk, n_fail;
  bit done;

  odt_pdw_tracker i_odt_pdw_tracker (
    .clk(clk), .rst_n(rst_n), .cke_q_i(cke_q_i), .ref_i(ref_i),
    .dll_frz_i(dll_frz_i), .wl_i(wl_i), .tcpded_i(tcpded_i),
    .trfc_i(trfc_i), .odt_i(odt_i), .mode_o(mode_o),
    .odt_dly_o(odt_dly_o), .odt_unc_o(odt_unc_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [1:0] m, input logic f,
                       input logic [1:0] em, input logic ef);
    n_chk++;
    if (m !== em || f !== ef) begin
      n_fail++;
      $display("FAIL %s: mode=%b flag=%b expected mode=%b flag=%b at %0t",
               req, m, f, em, ef, $time);
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; cke_q_i = 1'b1; ref_i = 1'b0; dll_frz_i = 1'b1; odt_i = 1'b0;
    wl_i = 5'd5; tcpded_i = 9'd1; trfc_i = 9'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", mode_o, odt_unc_o, 2'b00, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", mode_o, odt_unc_o, 2'b00, 1'b0);

    for (int s = 0; s < NSC; s++) begin
      int d, base, eoff, tend, en;
      scen_t sc;
      sc   = TBL[s];
      d    = sc.wl - 1;
      base = (sc.tc == 0) ? 0 : sc.tc - 1;
      eoff = base;
      if (sc.refk >= 0 && sc.trfc > 0 && sc.trfc - 1 - sc.refk > eoff)
        eoff = sc.trfc - 1 - sc.refk;
      en   = (sc.pdl > eoff + 1) ? sc.pdl : eoff + 1;
      tend = en + d + 5;
      for (int t = -20; t <= tend; t++) begin
        int n;
        logic [1:0] em;
        logic ef;
        @(posedge clk);
        #1;
        wl_i      = 5'(sc.wl);
        tcpded_i  = 9'(sc.tc);
        trfc_i    = 9'(sc.trfc);
        dll_frz_i = sc.frz[0];
        cke_q_i   = (t >= 0 && t < sc.pdl) ? 1'b0 : 1'b1;
        ref_i     = (sc.refk >= 0 && t == -sc.refk);
        odt_i     = (t >= sc.tog);
        @(negedge clk);
        n  = t - d;
        em = 2'b00;
        if (sc.frz != 0) begin
          if (n >= 1 - d && n <= eoff)      em = 2'b01;
          else if (n > eoff && n >= 0 && n < sc.pdl) em = 2'b10;
        end
        ef = (em == 2'b01) && (n == sc.tog);
        if (sc.frz == 0)        check("R2", mode_o, odt_unc_o, em, ef);
        else if (ef)            check("R7", mode_o, odt_unc_o, em, ef);
        else if (em == 2'b01)   check("R4", mode_o, odt_unc_o, em, ef);
        else if (em == 2'b10)   check("R6", mode_o, odt_unc_o, em, ef);
        else                    check("R3", mode_o, odt_unc_o, em, ef);
        if (t >= d - 20) begin
          n_chk++;
          if (odt_dly_o !== (n >= sc.tog)) begin
            n_fail++;
            $display("FAIL R7 odt_dly: got %b expected %b", odt_dly_o, (n >= sc.tog));
          end
        end
      end
    end

    // R8 out-of-range write latency behaves as 16: window opens 14 cycles before c0
    @(posedge clk); #1;
    wl_i = 5'd31; tcpded_i = 9'd1; dll_frz_i = 1'b1; odt_i = 1'b0; cke_q_i = 1'b1;
    repeat (20) @(posedge clk);
    #1 cke_q_i = 1'b0;
    @(negedge clk);
    check("R8 clamp excluded", mode_o, odt_unc_o, 2'b00, 1'b0);
    @(negedge clk);
    check("R8 clamp start", mode_o, odt_unc_o, 2'b01, 1'b0);

    // R1 reset during a window returns to synchronous
    @(posedge clk); #1;
    cke_q_i = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R1 mid-window reset", mode_o, odt_unc_o, 2'b00, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 post reset", mode_o, odt_unc_o, 2'b00, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule